// File: doc/BRIEF.md
# USB Device Command and Frame-Number Port

This block sits between a local microcontroller and a USB device core. It accepts a byte-wide command or data write from the controller, decodes the command bytes, and serves data reads back over a single byte-wide read port. Two commands are handled. The validate command (0xFA) arms the currently selected IN buffer, so the device core knows its contents may be sent on the next IN token. The frame-number command (0xF5) opens a read phase that returns the frame number taken from the last good SOF, one byte per read.

The frame counter is 11 bits wide and the read port is 8 bits wide, so the value comes out low byte first and high byte second. A controller that only needs the low 8 bits may stop after one read. The value is frozen when the command is accepted, so an SOF that lands between the two reads cannot mix bytes from two different frames. An SOF flagged as erroneous leaves the stored frame number alone. The IN-token-served pulse from the device core clears the buffer-full flag again.

Top module: `usbCmdPort`

## Requirements
- R1: While reset is asserted and after it is released, `bufFull` is 0 and `rdData` is 0x00.
- R2: A command write of 0xFA sets `bufFull` at the clock edge that samples it. It has no data phase, so a read that follows returns 0x00.
- R3: A pulse on `inServed` clears `bufFull` at the next edge. If a 0xFA command arrives in the same cycle, `bufFull` is set.
- R4: After a 0xF5 command, the first read returns frame bits 7:0.
- R5: The second read after 0xF5 returns frame bits 10:8 in bits 2:0, with bits 7:3 equal to 0. Any further read returns 0x00.
- R6: The stored frame number is the `sofFrame` value of the most recent `sofPulse` that had `sofError` low. A pulse with `sofError` high changes nothing.
- R7: The frame number is frozen when 0xF5 is accepted. An SOF between the two reads does not change the bytes returned.
- R8: Any command byte abandons a pending read phase. A read issued with no phase pending returns 0x00.
- R9: A data write (`wrIsCmd` low) is ignored. It neither starts nor ends a read phase, and it does not change `bufFull`.
- R10: `rdData` is loaded only at an edge that samples `rdStrobe` high and holds its value otherwise. If a read and a command write are sampled at the same edge, the command takes effect and the read returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrStrobe | input | 1 | One-cycle write strobe from the controller |
| wrIsCmd | input | 1 | 1: write carries a command byte; 0: data byte |
| wrData | input | DATA_W | Written byte |
| rdStrobe | input | 1 | One-cycle data read strobe |
| rdData | output | DATA_W | Byte returned by the last read |
| sofPulse | input | 1 | SOF received |
| sofError | input | 1 | The SOF marked by `sofPulse` was damaged |
| sofFrame | input | FRAME_W | Frame number carried by the SOF |
| inServed | input | 1 | The IN buffer contents were sent to the host |
| bufFull | output | 1 | IN buffer holds validated data |

## Verification
The bench builds the block with its default parameters: an 11-bit frame and an 8-bit port, which gives two read bytes and a 3-bit high field. At this size every one of the 2048 frame values can be captured and read back in full. Every one of the 256 command bytes can also be written and its effect on `bufFull` and on the read phase checked. Expected bytes are computed directly from the frame value by masking and shifting.

// File: rtl/usbCmdPkg.sv
package usbCmdPkg;
  // Strobes from the control side to the datapath, valid for one cycle.
  typedef struct packed {
    logic setFull;   // validate command accepted
    logic takeSnap;  // frame-number command accepted: freeze the frame
    logic readByte;  // load the selected snapshot byte into rdData
    logic readZero;  // load 0x00 into rdData
  } ctrlStrobe_t;
endpackage

// File: rtl/usbCmdCtrl.sv
module usbCmdCtrl
  import usbCmdPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NUM_BYTES = 2,
  parameter int IDX_W = 2,
  parameter logic [DATA_W-1:0] CMD_VALIDATE = 8'hFA,
  parameter logic [DATA_W-1:0] CMD_FRAME = 8'hF5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStrobe,
  input  logic              wrIsCmd,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdStrobe,
  output ctrlStrobe_t       strobes,
  output logic [IDX_W-1:0]  byteIdx
);
  // phase 0: no read pending; phase k: next read returns byte k-1
  logic [IDX_W-1:0] phase;
  logic cmdWrite;
  logic pending;
  logic lastByte;

  assign cmdWrite = wrStrobe && wrIsCmd;
  assign pending  = (phase != '0);
  assign lastByte = (phase == IDX_W'(NUM_BYTES));

  always_comb begin
    strobes.setFull  = cmdWrite && (wrData == CMD_VALIDATE);
    strobes.takeSnap = cmdWrite && (wrData == CMD_FRAME);
    strobes.readByte = rdStrobe && !cmdWrite && pending;
    strobes.readZero = rdStrobe && !(rdStrobe && !cmdWrite && pending);
    byteIdx          = pending ? phase - IDX_W'(1) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= '0;
    end else if (cmdWrite) begin
      phase <= (wrData == CMD_FRAME) ? IDX_W'(1) : '0;
    end else if (rdStrobe && pending) begin
      phase <= lastByte ? '0 : phase + IDX_W'(1);
    end
  end
endmodule

// File: rtl/usbFrameDatapath.sv
module usbFrameDatapath
  import usbCmdPkg::*;
#(
  parameter int FRAME_W = 11,
  parameter int DATA_W = 8,
  parameter int NUM_BYTES = 2,
  parameter int IDX_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobes,
  input  logic [IDX_W-1:0]   byteIdx,
  input  logic               sofPulse,
  input  logic               sofError,
  input  logic [FRAME_W-1:0] sofFrame,
  input  logic               inServed,
  output logic [DATA_W-1:0]  rdData,
  output logic               bufFull
);
  localparam int SNAP_W = NUM_BYTES * DATA_W;

  logic [FRAME_W-1:0] lastFrame;
  logic [SNAP_W-1:0]  snap;
  logic [DATA_W-1:0]  byteLane [NUM_BYTES];
  logic [DATA_W-1:0]  selByte;

  // Frame number from the last good SOF
  always_ff @(posedge clk) begin
    if (!rstN) lastFrame <= '0;
    else if (sofPulse && !sofError) lastFrame <= sofFrame;
  end

  // Snapshot frozen at the frame-number command, zero-extended
  always_ff @(posedge clk) begin
    if (!rstN) snap <= '0;
    else if (strobes.takeSnap) snap <= SNAP_W'(lastFrame);
  end

  for (genvar g = 0; g < NUM_BYTES; g++) begin : gLane
    assign byteLane[g] = snap[g*DATA_W +: DATA_W];
  end

  always_comb begin
    selByte = '0;
    for (int i = 0; i < NUM_BYTES; i++) begin
      if (byteIdx == IDX_W'(i)) selByte = byteLane[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else if (strobes.readByte) rdData <= selByte;
    else if (strobes.readZero) rdData <= '0;
  end

  // Validation wins over a same-cycle served pulse
  always_ff @(posedge clk) begin
    if (!rstN) bufFull <= 1'b0;
    else if (strobes.setFull) bufFull <= 1'b1;
    else if (inServed) bufFull <= 1'b0;
  end
endmodule

// File: rtl/usbCmdPort.sv
module usbCmdPort
  import usbCmdPkg::*;
#(
  parameter int FRAME_W = 11,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] CMD_VALIDATE = 8'hFA,
  parameter logic [DATA_W-1:0] CMD_FRAME = 8'hF5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrStrobe,
  input  logic               wrIsCmd,
  input  logic [DATA_W-1:0]  wrData,
  input  logic               rdStrobe,
  output logic [DATA_W-1:0]  rdData,
  input  logic               sofPulse,
  input  logic               sofError,
  input  logic [FRAME_W-1:0] sofFrame,
  input  logic               inServed,
  output logic               bufFull
);
  localparam int NUM_BYTES = (FRAME_W + DATA_W - 1) / DATA_W;
  localparam int IDX_W = $clog2(NUM_BYTES + 1);

  ctrlStrobe_t      strobes;
  logic [IDX_W-1:0] byteIdx;

  usbCmdCtrl #(
    .DATA_W(DATA_W), .NUM_BYTES(NUM_BYTES), .IDX_W(IDX_W),
    .CMD_VALIDATE(CMD_VALIDATE), .CMD_FRAME(CMD_FRAME)
  ) ctrl (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .wrIsCmd(wrIsCmd),
    .wrData(wrData), .rdStrobe(rdStrobe), .strobes(strobes), .byteIdx(byteIdx)
  );

  usbFrameDatapath #(
    .FRAME_W(FRAME_W), .DATA_W(DATA_W), .NUM_BYTES(NUM_BYTES), .IDX_W(IDX_W)
  ) dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .byteIdx(byteIdx),
    .sofPulse(sofPulse), .sofError(sofError), .sofFrame(sofFrame),
    .inServed(inServed), .rdData(rdData), .bufFull(bufFull)
  );
endmodule

// File: rtl/usbCmdPort_chk.sv
module usbCmdPort_chk #(
  parameter int FRAME_W = 11,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] CMD_VALIDATE = 8'hFA,
  parameter logic [DATA_W-1:0] CMD_FRAME = 8'hF5
) (
  input logic               clk,
  input logic               rstN,
  input logic               wrStrobe,
  input logic               wrIsCmd,
  input logic [DATA_W-1:0]  wrData,
  input logic               rdStrobe,
  input logic [DATA_W-1:0]  rdData,
  input logic               sofPulse,
  input logic               sofError,
  input logic [FRAME_W-1:0] sofFrame,
  input logic               inServed,
  input logic               bufFull
);
  // R2
  full_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bufFull) |-> $past(wrStrobe && wrIsCmd && wrData == CMD_VALIDATE));

  // R3
  full_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(bufFull) |-> $past(inServed));

  // R3
  validate_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && wrIsCmd && wrData == CMD_VALIDATE) |=> bufFull);

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdStrobe |=> $stable(rdData));

  // R10
  rd_collide_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && wrStrobe && wrIsCmd) |=> (rdData == '0));

  // R8
  abandon_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && wrIsCmd && wrData != CMD_FRAME) ##1 (rdStrobe && !wrStrobe)
      |=> (rdData == '0));
endmodule

bind usbCmdPort usbCmdPort_chk #(
  .FRAME_W(FRAME_W), .DATA_W(DATA_W),
  .CMD_VALIDATE(CMD_VALIDATE), .CMD_FRAME(CMD_FRAME)
) chk (.*);

// File: tb/usbCmdPort_test.sv
`timescale 1ns/100ps
module usbCmdPort_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrStrobe = 1'b0;
  logic        wrIsCmd = 1'b0;
  logic [7:0]  wrData = '0;
  logic        rdStrobe = 1'b0;
  logic [7:0]  rdData;
  logic        sofPulse = 1'b0;
  logic        sofError = 1'b0;
  logic [10:0] sofFrame = '0;
  logic        inServed = 1'b0;
  logic        bufFull;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  usbCmdPort uut (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .wrIsCmd(wrIsCmd),
    .wrData(wrData), .rdStrobe(rdStrobe), .rdData(rdData),
    .sofPulse(sofPulse), .sofError(sofError), .sofFrame(sofFrame),
    .inServed(inServed), .bufFull(bufFull)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic isCmd, logic [7:0] b);
    @(negedge clk);
    wrStrobe = 1'b1; wrIsCmd = isCmd; wrData = b;
    @(negedge clk);
    wrStrobe = 1'b0; wrIsCmd = 1'b0;
  endtask

  task automatic rd(output logic [7:0] v);
    @(negedge clk);
    rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0;
    v = rdData;
  endtask

  task automatic sof(logic [10:0] f, logic err);
    @(negedge clk);
    sofPulse = 1'b1; sofError = err; sofFrame = f;
    @(negedge clk);
    sofPulse = 1'b0; sofError = 1'b0;
  endtask

  task automatic served();
    @(negedge clk);
    inServed = 1'b1;
    @(negedge clk);
    inServed = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] keep;
    repeat (3) @(negedge clk);
    // R1 during and after reset
    check("R1", {31'd0, bufFull}, 0);
    check("R1", {24'd0, rdData}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", {31'd0, bufFull}, 0);
    check("R1", {24'd0, rdData}, 0);

    // R6 R4 R5 sweep over all frame values
    for (int f = 0; f < 2048; f++) begin
      sof(11'(f), 1'b0);
      wr(1'b1, 8'hF5);
      rd(v); check("R4", {24'd0, v}, f & 8'hFF);
      rd(v); check("R5", {24'd0, v}, f >> 8);
      if (f % 256 == 5) begin
        rd(v); check("R5", {24'd0, v}, 0);
      end
    end

    // R6 erroneous SOF ignored
    sof(11'h2A5, 1'b0);
    sof(11'h15A, 1'b1);
    wr(1'b1, 8'hF5);
    rd(v); check("R6", {24'd0, v}, 8'hA5);
    rd(v); check("R6", {24'd0, v}, 8'h02);

    // R7 snapshot survives an SOF between reads
    sof(11'h123, 1'b0);
    wr(1'b1, 8'hF5);
    rd(v); check("R7", {24'd0, v}, 8'h23);
    sof(11'h7FF, 1'b0);
    rd(v); check("R7", {24'd0, v}, 8'h01);
    wr(1'b1, 8'hF5);
    rd(v); check("R7", {24'd0, v}, 8'hFF);
    rd(v); check("R7", {24'd0, v}, 8'h07);

    // R2 R3 validate and served
    wr(1'b1, 8'hFA);
    check("R2", {31'd0, bufFull}, 1);
    rd(v); check("R2", {24'd0, v}, 0);
    served();
    check("R3", {31'd0, bufFull}, 0);
    @(negedge clk);
    wrStrobe = 1'b1; wrIsCmd = 1'b1; wrData = 8'hFA; inServed = 1'b1;
    @(negedge clk);
    wrStrobe = 1'b0; wrIsCmd = 1'b0; inServed = 1'b0;
    check("R3", {31'd0, bufFull}, 1);
    served();
    check("R3", {31'd0, bufFull}, 0);

    // Exhaustive command sweep: R2 R8
    sof(11'h3C4, 1'b0);
    for (int c = 0; c < 256; c++) begin
      wr(1'b1, 8'hF5);
      rd(v);
      wr(1'b1, 8'(c));
      check("R2", {31'd0, bufFull}, (c == 8'hFA) ? 1 : 0);
      rd(v);
      check("R8", {24'd0, v}, (c == 8'hF5) ? 8'hC4 : 0);
      served();
    end

    // R9 data writes ignored
    wr(1'b1, 8'hF5);
    wr(1'b0, 8'hF5);
    rd(v); check("R9", {24'd0, v}, 8'hC4);
    wr(1'b0, 8'hFA);
    check("R9", {31'd0, bufFull}, 0);
    rd(v); check("R9", {24'd0, v}, 8'h03);
    wr(1'b1, 8'hF5);
    wr(1'b0, 8'h00);
    rd(v); check("R9", {24'd0, v}, 8'hC4);

    // R10 hold and collision
    keep = rdData;
    repeat (4) @(negedge clk);
    check("R10", {24'd0, rdData}, {24'd0, keep});
    wr(1'b1, 8'hF5);
    @(negedge clk);
    rdStrobe = 1'b1; wrStrobe = 1'b1; wrIsCmd = 1'b1; wrData = 8'hF5;
    @(negedge clk);
    rdStrobe = 1'b0; wrStrobe = 1'b0; wrIsCmd = 1'b0;
    check("R10", {24'd0, rdData}, 0);
    rd(v); check("R10", {24'd0, v}, 8'hC4);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule